// File: doc/BRIEF.md
# Serial Polynomial-Division Signature Register

This block compacts a serial response stream from a circuit under self-test into a short signature. Every accepted bit is shifted into a five-stage register that divides by the generator x^5 + x^3 + x + 1 over GF(2). Each bit that leaves the top stage is a quotient coefficient. That bit is folded back into stages 3, 1 and 0, because x^5 reduces to x^3 + x + 1 modulo the generator. The message is presented highest-order coefficient first and the register starts from zero. After the last bit, the register therefore holds the exact remainder of the message polynomial divided by the generator.

The stream length and the expected (golden) signature are inputs. A bit counter tracks how many bits have been absorbed. Once the counter reaches the programmed length, the register stops accepting data. A small verdict machine then compares the signature with the golden value and latches the result. Any stream that differs from the good one by a multiple of the generator gives the same signature. This aliasing is inherent to the method and the block reproduces it faithfully.

The verdict machine has four states:
- IDLE: entered on clear, before any bit is taken.
- ACCUM: bits are being absorbed.
- MATCH: the verdict was equal.
- MISMATCH: the verdict was unequal.

It has these transitions:
- clear: any state to IDLE.
- first_bit: IDLE to ACCUM, on an accepted bit while the count is below the length.
- judge_eq: IDLE or ACCUM to MATCH, when the count equals the length and the signature equals the golden value.
- judge_ne: IDLE or ACCUM to MISMATCH, when the count equals the length and the signature differs.
- hold: MATCH and MISMATCH stay where they are.

Top module: `serial_sig_compactor`

## Requirements
- R1: In the cycle after `clr` is sampled high, `signature` is 0, `bit_count` is 0 and `sig_pass` is 0.
- R2: An accepted bit `d` updates the register as follows, with s[0] the x^0 stage, s[4] the x^4 stage and f = s[4]: s0'=d^f, s1'=s0^f, s2'=s1, s3'=s2^f, s4'=s3.
- R3: A cycle with `din_valid` low leaves `signature` and `bit_count` unchanged.
- R4: Each accepted bit increments `bit_count` by exactly one. A bit is accepted when `din_valid` is high and `bit_count` is below `stream_len`.
- R5: After `stream_len` accepted bits, `signature` equals the remainder of the message (first bit = highest power) divided by x^5+x^3+x+1. For example, the stream 10001010 gives 01101 (x^3+x^2+1).
- R6: Once `bit_count` equals `stream_len`, further valid bits change neither `signature` nor `bit_count`.
- R7: One cycle after `bit_count` first equals `stream_len`, `sig_pass` rises if `signature` equals `golden_sig`. It stays low otherwise, and it is never high before that cycle.
- R8: A verdict holds until the next clear. Changing `golden_sig` afterwards has no effect on `sig_pass`.
- R9: A stream that differs from the good stream by a multiple of the generator gives the same signature and passes. For example, 10100001 (x^7+x^5+1) gives 01101.
- R10: With `stream_len` = 0, the verdict is taken one cycle after clear on the all-zero signature.
- R11: A clear in the middle of a stream discards it, and a new stream starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear of register, counter and verdict |
| din_valid | input | 1 | Bit strobe |
| din_bit | input | 1 | Serial response bit |
| golden_sig | input | SIG_W (5) | Expected signature |
| stream_len | input | CNT_W (16) | Number of bits in the stream |
| signature | output | SIG_W (5) | Current remainder |
| bit_count | output | CNT_W (16) | Bits absorbed since clear |
| sig_pass | output | 1 | Latched equal verdict |

## Verification
A wrong feedback tap or a wrong shift shows at `signature` on the cycle after the first accepted bit that carries a one out of the top stage. The bench compares the register against a long-division model after every accepted bit, so such an error is flagged within one cycle. A counter that drifts, or a stage that moves while the strobe is low, shows at `bit_count` or `signature` on the next cycle. A verdict machine that leaves MATCH or judges early shows at `sig_pass` within one cycle of the count reaching the length.

// File: rtl/sigc_pkg.sv
package sigc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACCUM    = 2'd1,
        ST_MATCH    = 2'd2,
        ST_MISMATCH = 2'd3
    } sigc_state_t;

    // Low-order terms of x^5 + x^3 + x + 1 (bit i = coefficient of x^i)
    localparam logic [4:0] GEN_LOW_TERMS = 5'b01011;

endpackage

// File: rtl/sigc_divider.sv
module sigc_divider #(
    parameter int          SIG_W = 5,
    parameter logic [SIG_W-1:0] TAPS = 5'b01011
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             din,
    output logic [SIG_W-1:0] rem_o
);

    logic [SIG_W-1:0] rem_q;
    logic [SIG_W-1:0] rem_d;
    logic             carry_out;

    assign carry_out = rem_q[SIG_W-1];

    for (genvar i = 0; i < SIG_W; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign rem_d[i] = din ^ (TAPS[i] & carry_out);
        end else begin : g_body
            assign rem_d[i] = rem_q[i-1] ^ (TAPS[i] & carry_out);
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            rem_q <= '0;
        end else if (shift_en) begin
            rem_q <= rem_d;
        end
    end

    assign rem_o = rem_q;

endmodule

// File: rtl/sigc_counter.sv
module sigc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_limit_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o      = cnt_q;
    assign at_limit_o = (cnt_q == limit);

endmodule

// File: rtl/sigc_verdict_fsm.sv
module sigc_verdict_fsm
    import sigc_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic at_limit,
    input  logic sig_match,
    input  logic bit_taken,
    output logic take_ok_o,
    output logic pass_o
);

    sigc_state_t state_q;
    sigc_state_t state_d;

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (at_limit) begin
                    state_d = sig_match ? ST_MATCH : ST_MISMATCH;
                end else if (bit_taken) begin
                    state_d = ST_ACCUM;
                end
            end
            ST_ACCUM: begin
                if (at_limit) begin
                    state_d = sig_match ? ST_MATCH : ST_MISMATCH;
                end
            end
            ST_MATCH:    state_d = ST_MATCH;
            ST_MISMATCH: state_d = ST_MISMATCH;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_ok_o = 1'b0;
        pass_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:     take_ok_o = 1'b1;
            ST_ACCUM:    take_ok_o = 1'b1;
            ST_MATCH:    pass_o    = 1'b1;
            ST_MISMATCH: pass_o    = 1'b0;
            default:     pass_o    = 1'b0;
        endcase
    end

endmodule

// File: rtl/serial_sig_compactor.sv
module serial_sig_compactor #(
    parameter int SIG_W = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             din_valid,
    input  logic             din_bit,
    input  logic [SIG_W-1:0] golden_sig,
    input  logic [CNT_W-1:0] stream_len,
    output logic [SIG_W-1:0] signature,
    output logic [CNT_W-1:0] bit_count,
    output logic             sig_pass
);

    localparam logic [SIG_W-1:0] TAPS = sigc_pkg::GEN_LOW_TERMS;

    logic at_limit;
    logic take_ok;
    logic bit_taken;
    logic sig_match;

    assign bit_taken = din_valid & take_ok & ~at_limit;
    assign sig_match = (signature == golden_sig);

    sigc_divider #(
        .SIG_W (SIG_W),
        .TAPS  (TAPS)
    ) div_i (
        .clk      (clk),
        .clr      (clr),
        .shift_en (bit_taken),
        .din      (din_bit),
        .rem_o    (signature)
    );

    sigc_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk        (clk),
        .clr        (clr),
        .inc        (bit_taken),
        .limit      (stream_len),
        .cnt_o      (bit_count),
        .at_limit_o (at_limit)
    );

    sigc_verdict_fsm fsm_i (
        .clk       (clk),
        .clr       (clr),
        .at_limit  (at_limit),
        .sig_match (sig_match),
        .bit_taken (bit_taken),
        .take_ok_o (take_ok),
        .pass_o    (sig_pass)
    );

endmodule

// File: rtl/sigc_checker.sv
module sigc_checker #(
    parameter int SIG_W = 5,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             clr,
    input logic             din_valid,
    input logic [SIG_W-1:0] golden_sig,
    input logic [CNT_W-1:0] stream_len,
    input logic [SIG_W-1:0] signature,
    input logic [CNT_W-1:0] bit_count,
    input logic             sig_pass
);

    // R1: clear empties everything
    p_clear_zero_r1: assert property (@(posedge clk)
        clr |=> (signature == '0 && bit_count == '0 && !sig_pass));

    // R3: idle strobe leaves state alone
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (clr)
        !din_valid |=> ($stable(signature) && $stable(bit_count)));

    // R4: one step per accepted bit
    p_count_step_r4: assert property (@(posedge clk) disable iff (clr)
        (din_valid && bit_count < stream_len) |=>
            (bit_count == $past(bit_count) + CNT_W'(1)));

    // R6: frozen once length reached
    p_freeze_r6: assert property (@(posedge clk) disable iff (clr)
        (bit_count == stream_len) |=> ($stable(signature) && $stable(bit_count)));

    // R7: rising verdict only on an equal compare
    p_pass_match_r7: assert property (@(posedge clk) disable iff (clr)
        $rose(sig_pass) |-> (signature == $past(golden_sig)));

    // R8: verdict sticks until clear
    p_pass_hold_r8: assert property (@(posedge clk) disable iff (clr)
        sig_pass |=> sig_pass);

endmodule

bind serial_sig_compactor sigc_checker #(
    .SIG_W (SIG_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk        (clk),
    .clr        (clr),
    .din_valid  (din_valid),
    .golden_sig (golden_sig),
    .stream_len (stream_len),
    .signature  (signature),
    .bit_count  (bit_count),
    .sig_pass   (sig_pass)
);

// File: tb/serial_sig_compactor_tb_top.sv
module serial_sig_compactor_tb_top;

    localparam int SIG_W = 5;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             clr = 1'b1;
    logic             din_valid = 1'b0;
    logic             din_bit = 1'b0;
    logic [SIG_W-1:0] golden_sig = '0;
    logic [CNT_W-1:0] stream_len = '0;
    logic [SIG_W-1:0] signature;
    logic [CNT_W-1:0] bit_count;
    logic             sig_pass;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_sig_compactor #(.SIG_W(SIG_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .clr(clr), .din_valid(din_valid), .din_bit(din_bit),
        .golden_sig(golden_sig), .stream_len(stream_len),
        .signature(signature), .bit_count(bit_count), .sig_pass(sig_pass)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Long division by 101011, first bit = highest power
    function automatic logic [4:0] ref_rem(input logic [63:0] msg, input int n);
        logic [5:0] r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            r = {r[4:0], msg[i]};
            if (r[5]) r = r ^ 6'b101011;
        end
        return r[4:0];
    endfunction

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        din_valid = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        chk(signature == '0, "R1", "signature after clear", signature, 0);
        chk(bit_count == '0, "R1", "count after clear", bit_count, 0);
        chk(sig_pass == 1'b0, "R1", "pass after clear", sig_pass, 0);
    endtask

    task automatic run_stream(input logic [63:0] msg, input int n,
                              input logic [4:0] gold, input int gap_pct,
                              input string req);
        logic [4:0] prev;
        logic [4:0] exp_sig;
        stream_len = CNT_W'(n);
        golden_sig = gold;
        do_clear();
        for (int i = n - 1; i >= 0; i--) begin
            while ($urandom_range(99, 0) < gap_pct) begin
                prev = signature;
                din_valid = 1'b0;
                din_bit = 1'($urandom);
                @(negedge clk);
                chk(signature == prev, "R3", "signature moved on gap", signature, prev);
            end
            din_valid = 1'b1;
            din_bit = msg[i];
            @(negedge clk);
            din_valid = 1'b0;
            exp_sig = ref_rem(msg >> i, n - i);
            chk(signature == exp_sig, "R2", "step signature", signature, exp_sig);
            chk(bit_count == CNT_W'(n - i), "R4", "count step", bit_count, n - i);
        end
        exp_sig = ref_rem(msg, n);
        chk(signature == exp_sig, req, "final signature", signature, exp_sig);
        chk(sig_pass == 1'b0, "R7", "pass before verdict", sig_pass, 0);
        @(negedge clk);
        chk(sig_pass == (exp_sig == gold), "R7", "verdict", sig_pass,
            int'(exp_sig == gold));
    endtask

    initial begin
        logic [63:0] msg;
        logic [4:0]  sig_hold;
        logic [4:0]  gold;
        int          n;
        bit          v;
        void'($urandom(32'h5eed_0042));

        // R1 plus R5: worked example, 10001010 -> 01101
        run_stream(64'b10001010, 8, 5'b01101, 0, "R5");
        chk(signature == 5'b01101, "R5", "example remainder", signature, 5'b01101);

        // R6: extra bits ignored after completion
        sig_hold = signature;
        for (int k = 0; k < 6; k++) begin
            din_valid = 1'b1;
            din_bit = 1'($urandom);
            @(negedge clk);
            chk(signature == sig_hold, "R6", "signature after length", signature, sig_hold);
            chk(bit_count == 16'd8, "R6", "count after length", bit_count, 8);
        end
        din_valid = 1'b0;

        // R8: golden change after verdict does not matter
        golden_sig = 5'b10010;
        repeat (3) @(negedge clk);
        chk(sig_pass == 1'b1, "R8", "pass held", sig_pass, 1);

        // R9: aliasing stream 10100001
        run_stream(64'b10100001, 8, 5'b01101, 30, "R9");
        chk(sig_pass == 1'b1, "R9", "alias passes", sig_pass, 1);

        // R7: wrong golden never passes
        run_stream(64'b10001010, 8, 5'b01100, 0, "R5");
        repeat (3) @(negedge clk);
        chk(sig_pass == 1'b0, "R7", "mismatch stays low", sig_pass, 0);

        // R10: zero length
        run_stream(64'd0, 0, 5'b00000, 0, "R10");
        chk(sig_pass == 1'b1, "R10", "zero length pass", sig_pass, 1);
        run_stream(64'd0, 0, 5'b00001, 0, "R10");
        chk(sig_pass == 1'b0, "R10", "zero length mismatch", sig_pass, 0);

        // R11: clear mid-stream, then a fresh stream
        stream_len = 16'd20;
        golden_sig = 5'b0;
        do_clear();
        for (int k = 0; k < 7; k++) begin
            din_valid = 1'b1;
            din_bit = 1'b1;
            @(negedge clk);
        end
        din_valid = 1'b0;
        do_clear();
        chk(bit_count == '0, "R11", "count restarted", bit_count, 0);
        run_stream(64'hB5, 8, ref_rem(64'hB5, 8), 20, "R11");

        // Random streams
        for (int t = 0; t < 40; t++) begin
            n = $urandom_range(40, 1);
            msg = {$urandom, $urandom};
            v = 1'($urandom);
            gold = v ? ref_rem(msg, n) : (ref_rem(msg, n) ^ 5'(($urandom_range(30, 0)) + 1));
            run_stream(msg, n, gold, 25, "R5");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule